// File: doc/BRIEF.md
# SDRAM Burst Sequencer with Auto-Precharge

This block sits on the controller side of a four-bank SDRAM and runs one read or write burst at a time against a row that is already open. A request names an operation (read, write, explicit precharge or burst stop), a bank, a column and a close flag. The sequencer drives the command bus one cycle after it accepts a request and paces the data beats. It raises a read-valid strobe once the CAS latency has passed, and a write-take strobe while write data must be on the bus. It also decides in which cycle each bank is closed.

A burst may end in four ways: it runs to its natural end, a burst stop cuts it short and leaves the row open, a newer read or write replaces it, or a precharge to its bank shuts it down. When the close flag was set and the burst ran to completion, the bank closes automatically. For a read this happens CL-1 clocks before its last data. For a write it happens tWR clocks after its last data. Every close, automatic or explicit, is reported as a per-bank mask in the cycle the precharge begins. A write that arrives while read data is still in flight is held back until the data bus has turned around.

Top module: `sdr_burst_seq`

## Requirements
- R1: A request accepted at a clock edge (req_valid and req_ready high) appears on the command bus in the next cycle. The code on {ras_n, cas_n, we_n} is read 101, write 100, precharge 010, burst stop 110, and idle 111 otherwise. For read and write, sdr_addr carries the column in bits 9:0 and the close flag in bit 10, and sdr_ba carries the bank. For precharge, sdr_addr bit 10 carries the all-banks flag.
- R2: For a read whose command shows in cycle C, rd_valid is high for cycles C+CL through C+CL+N-1, where N = 1, 2, 4 or 8 for cfg_bl codes 0 to 3 and CL is cfg_cl (2, 3 or 4).
- R3: For a write whose command shows in cycle C, wr_take is high for cycles C through C+N-1.
- R4: A read with its close flag set that runs to completion closes its bank in cycle C+N, which is CL-1 clocks before its last data.
- R5: A write with its close flag set that runs to completion closes its bank cfg_twr cycles after its last wr_take cycle.
- R6: A read or write with its close flag clear never closes its bank.
- R7: A burst stop showing in cycle S suppresses every beat whose command-side slot is S or later. Write beats from S on never raise wr_take, and read data for those beats never appears. The bank stays open even when the close flag was set.
- R8: A new read or write cuts the burst in progress: its beats replace the old ones from its own command cycle on, and the old burst's automatic close is dropped.
- R9: An explicit precharge raises close_mask for its bank, or for all four banks when the all-banks flag is set, in the cycle it shows on the bus. It cuts the running burst only when it targets that burst's bank or all banks.
- R10: A write is not accepted (req_ready low) while read data is pending, and at least one cycle with neither rd_valid nor wr_take separates the last read data from the first write beat. Reads, precharges and stops are never held.
- R11: Close events for different banks that fall in the same cycle all appear together in close_mask, and close_evt is high in any cycle with a close.
- R12: Reset returns the bus to idle, drops every pending beat and pending close, and leaves rd_valid, wr_take and close_mask low with req_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 precharge, 3 burst stop |
| req_bank | input | 2 | Target bank |
| req_col | input | 10 | Column for read or write |
| req_ap | input | 1 | Close flag for read/write; all-banks flag for precharge |
| req_ready | output | 1 | Request can be accepted this cycle |
| cfg_bl | input | 2 | Burst length code (beats = 1 << code) |
| cfg_cl | input | 3 | CAS latency in clocks, 2 to 4 |
| cfg_twr | input | 3 | Write recovery in clocks, 1 to 7 |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_addr | output | 13 | Address bus |
| sdr_ba | output | 2 | Bank address |
| rd_valid | output | 1 | Read data present on the bus this cycle |
| wr_take | output | 1 | Write data must be driven this cycle |
| close_evt | output | 1 | A bank starts precharging this cycle |
| close_mask | output | 4 | Banks starting precharge this cycle |

## Verification
The automatic close of a write burst, counted off by the write-recovery timer, can land in the same cycle as an explicit precharge that another request sends to a different bank. The bench provokes this with a one-beat write to bank 0 that has its close flag set and tWR of three. It then times a precharge to bank 2 so that it reaches the bus exactly three cycles after that write beat. The result is correct only if close_mask shows both bank bits in that one cycle and nothing in the cycles around it.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // Command codes as {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_PRE   = 3'b010,
        CMD_WRITE = 3'b100,
        CMD_READ  = 3'b101,
        CMD_BST   = 3'b110,
        CMD_NOP   = 3'b111
    } sdr_cmd_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_PRE   = 2'd2,
        OP_STOP  = 2'd3
    } seq_op_e;

    localparam int BLC_W     = 2;
    localparam int MAX_BEATS = 1 << ((1 << BLC_W) - 1);
    localparam int CNT_W     = $clog2(MAX_BEATS);

    // Beats remaining after the first one, for a burst length code
    function automatic logic [CNT_W-1:0] beats_after_first(input logic [BLC_W-1:0] code);
        return CNT_W'((1 << code) - 1);
    endfunction

endpackage

// File: rtl/sdr_cmd_issue.sv
module sdr_cmd_issue
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 10,
    parameter int AP_BIT = 10,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  seq_op_e           op,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic              ap,
    input  logic [BLC_W-1:0]  bl_code,
    output sdr_cmd_e          cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic              beat_rd,
    output logic              beat_wr,
    output logic              arm_valid,
    output logic [BANK_W-1:0] arm_bank,
    output logic              arm_wr
);

    sdr_cmd_e          cmd_q, cmd_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [BANK_W-1:0] ba_q;

    // Burst in flight: beat_q marks a command-side beat slot this cycle
    logic              beat_q;
    logic [CNT_W-1:0]  left_q;
    logic              wr_q;
    logic              ap_q;
    logic [BANK_W-1:0] bank_q;

    logic is_access, hits_burst, kill, cont;

    assign is_access  = acc && (op == OP_READ || op == OP_WRITE);
    assign hits_burst = acc && op == OP_PRE && (ap || bank == bank_q);
    assign kill       = (acc && op == OP_STOP) || hits_burst;
    assign cont       = beat_q && (left_q != '0);

    always_comb begin
        cmd_d  = CMD_NOP;
        addr_d = '0;
        if (acc) begin
            unique case (op)
                OP_READ:  cmd_d = CMD_READ;
                OP_WRITE: cmd_d = CMD_WRITE;
                OP_PRE:   cmd_d = CMD_PRE;
                default:  cmd_d = CMD_BST;
            endcase
            if (is_access) begin
                addr_d[COL_W-1:0] = col;
                addr_d[AP_BIT]    = ap;
            end else if (op == OP_PRE) begin
                addr_d[AP_BIT]    = ap;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            ba_q   <= '0;
            beat_q <= 1'b0;
            left_q <= '0;
            wr_q   <= 1'b0;
            ap_q   <= 1'b0;
            bank_q <= '0;
        end else begin
            cmd_q  <= cmd_d;
            addr_q <= addr_d;
            ba_q   <= (acc && op != OP_STOP) ? bank : '0;
            if (is_access) begin
                beat_q <= 1'b1;
                left_q <= beats_after_first(bl_code);
                wr_q   <= (op == OP_WRITE);
                ap_q   <= ap;
                bank_q <= bank;
            end else if (kill) begin
                beat_q <= 1'b0;
                left_q <= '0;
            end else if (cont) begin
                left_q <= left_q - 1'b1;
            end else begin
                beat_q <= 1'b0;
            end
        end
    end

    assign cmd       = cmd_q;
    assign addr      = addr_q;
    assign ba        = ba_q;
    assign beat_rd   = beat_q && !wr_q;
    assign beat_wr   = beat_q && wr_q;
    // Final beat of an auto-closing burst: any later command comes too late to cut it
    assign arm_valid = beat_q && (left_q == '0) && ap_q;
    assign arm_bank  = bank_q;
    assign arm_wr    = wr_q;

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int MAX_CL = 4,
    parameter int CL_W   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            beat_rd,
    input  logic [CL_W-1:0] cl,
    output logic            rd_valid,
    output logic            rd_busy
);

    logic [MAX_CL-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[MAX_CL-2:0], beat_rd};
    end

    // Tap CL-1 is the beat issued CL cycles ago; anything at or before it is still owed
    always_comb begin
        int cl_i;
        cl_i = int'(cl);
        if (cl_i < 2)           cl_i = 2;
        else if (cl_i > MAX_CL) cl_i = MAX_CL;
        rd_valid = 1'b0;
        rd_busy  = beat_rd;
        for (int j = 0; j < MAX_CL; j++) begin
            if (j == cl_i - 1) rd_valid = pipe_q[j];
            if (j < cl_i)      rd_busy  = rd_busy | pipe_q[j];
        end
    end

endmodule

// File: rtl/sdr_close_timers.sv
module sdr_close_timers #(
    parameter int BANK_W = 2,
    parameter int TWR_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   arm_valid,
    input  logic [BANK_W-1:0]      arm_bank,
    input  logic                   arm_wr,
    input  logic [TWR_W-1:0]       twr,
    output logic [(1<<BANK_W)-1:0] fire
);

    localparam int NBANK = 1 << BANK_W;

    logic [TWR_W-1:0] delay;
    assign delay = (twr == '0) ? TWR_W'(1) : twr;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [TWR_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst)
                cnt_q <= '0;
            else if (arm_valid && arm_bank == BANK_W'(b))
                cnt_q <= arm_wr ? delay : TWR_W'(1);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
        assign fire[b] = (cnt_q == TWR_W'(1));
    end

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 10,
    parameter int AP_BIT = 10,
    parameter int BANK_W = 2,
    parameter int MAX_CL = 4,
    parameter int TWR_W  = 3,
    localparam int NBANK = 1 << BANK_W,
    localparam int CL_W  = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    output logic              req_ready,
    input  logic [BLC_W-1:0]  cfg_bl,
    input  logic [CL_W-1:0]   cfg_cl,
    input  logic [TWR_W-1:0]  cfg_twr,
    output logic              sdr_ras_n,
    output logic              sdr_cas_n,
    output logic              sdr_we_n,
    output logic [ADDR_W-1:0] sdr_addr,
    output logic [BANK_W-1:0] sdr_ba,
    output logic              rd_valid,
    output logic              wr_take,
    output logic              close_evt,
    output logic [NBANK-1:0]  close_mask
);

    seq_op_e           op;
    sdr_cmd_e          cmd;
    logic              acc, rd_busy, beat_rd, beat_wr;
    logic              arm_valid, arm_wr;
    logic [BANK_W-1:0] arm_bank;
    logic [NBANK-1:0]  fire, pre_mask;

    assign op        = seq_op_e'(req_op);
    assign req_ready = (op != OP_WRITE) || !rd_busy;
    assign acc       = req_valid && req_ready;

    sdr_cmd_issue #(
        .ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .BANK_W(BANK_W)
    ) u_issue (
        .clk(clk), .rst(rst), .acc(acc), .op(op), .bank(req_bank), .col(req_col),
        .ap(req_ap), .bl_code(cfg_bl), .cmd(cmd), .addr(sdr_addr), .ba(sdr_ba),
        .beat_rd(beat_rd), .beat_wr(beat_wr), .arm_valid(arm_valid),
        .arm_bank(arm_bank), .arm_wr(arm_wr)
    );

    sdr_rd_pipe #(.MAX_CL(MAX_CL), .CL_W(CL_W)) u_rdpipe (
        .clk(clk), .rst(rst), .beat_rd(beat_rd), .cl(cfg_cl),
        .rd_valid(rd_valid), .rd_busy(rd_busy)
    );

    sdr_close_timers #(.BANK_W(BANK_W), .TWR_W(TWR_W)) u_timers (
        .clk(clk), .rst(rst), .arm_valid(arm_valid), .arm_bank(arm_bank),
        .arm_wr(arm_wr), .twr(cfg_twr), .fire(fire)
    );

    always_comb begin
        pre_mask = '0;
        if (cmd == CMD_PRE) begin
            if (sdr_addr[AP_BIT]) pre_mask = '1;
            else                  pre_mask[sdr_ba] = 1'b1;
        end
    end

    assign sdr_ras_n  = cmd[2];
    assign sdr_cas_n  = cmd[1];
    assign sdr_we_n   = cmd[0];
    assign wr_take    = beat_wr;
    assign close_mask = fire | pre_mask;
    assign close_evt  = |close_mask;

endmodule

// File: rtl/sdr_seq_checks.sv
module sdr_seq_checks #(
    parameter int BANK_W = 2,
    localparam int NBANK = 1 << BANK_W
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        req_op,
    input logic              req_ready,
    input logic              sdr_ras_n,
    input logic              sdr_cas_n,
    input logic              sdr_we_n,
    input logic [BANK_W-1:0] sdr_ba,
    input logic              rd_valid,
    input logic              wr_take,
    input logic [NBANK-1:0]  close_mask
);

    logic [2:0] cmd_w;
    assign cmd_w = {sdr_ras_n, sdr_cas_n, sdr_we_n};

    p_cmd_code_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_w inside {3'b111, 3'b101, 3'b100, 3'b010, 3'b110});

    p_wr_cmd_beat_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_w == 3'b100 |-> wr_take);

    p_stop_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_w == 3'b110 |-> !wr_take);

    p_pre_close_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_w == 3'b010 |-> close_mask[sdr_ba]);

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && wr_take));

    p_turn_gap_r10: assert property (@(posedge clk) disable iff (rst)
        wr_take |-> !$past(rd_valid));

    p_never_hold_r10: assert property (@(posedge clk) disable iff (rst)
        req_op != 2'd1 |-> req_ready);

    p_reset_idle_r12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd_w == 3'b111 && !rd_valid && !wr_take && close_mask == '0));

endmodule

bind sdr_burst_seq sdr_seq_checks #(.BANK_W(BANK_W)) u_checks (
    .clk(clk), .rst(rst), .req_op(req_op), .req_ready(req_ready),
    .sdr_ras_n(sdr_ras_n), .sdr_cas_n(sdr_cas_n), .sdr_we_n(sdr_we_n),
    .sdr_ba(sdr_ba), .rd_valid(rd_valid), .wr_take(wr_take), .close_mask(close_mask)
);

// File: tb/sim_sdr_burst_seq.sv
module sim_sdr_burst_seq;

    localparam int LOGN = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [9:0]  req_col = 10'd0;
    logic        req_ap = 1'b0;
    logic        req_ready;
    logic [1:0]  cfg_bl = 2'd2;
    logic [2:0]  cfg_cl = 3'd2;
    logic [2:0]  cfg_twr = 3'd2;
    logic        sdr_ras_n, sdr_cas_n, sdr_we_n;
    logic [12:0] sdr_addr;
    logic [1:0]  sdr_ba;
    logic        rd_valid, wr_take, close_evt;
    logic [3:0]  close_mask;

    always #4 clk = ~clk;

    sdr_burst_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap), .req_ready(req_ready),
        .cfg_bl(cfg_bl), .cfg_cl(cfg_cl), .cfg_twr(cfg_twr),
        .sdr_ras_n(sdr_ras_n), .sdr_cas_n(sdr_cas_n), .sdr_we_n(sdr_we_n),
        .sdr_addr(sdr_addr), .sdr_ba(sdr_ba), .rd_valid(rd_valid), .wr_take(wr_take),
        .close_evt(close_evt), .close_mask(close_mask)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic       lg_rv [LOGN];
    logic       lg_wt [LOGN];
    logic [3:0] lg_cm [LOGN];
    logic       lg_ce [LOGN];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc < LOGN) begin
            lg_rv[cyc] = rd_valid;
            lg_wt[cyc] = wr_take;
            lg_cm[cyc] = close_mask;
            lg_ce[cyc] = close_evt;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; returns at the negedge of the cycle the command is on the bus
    task automatic issue(input logic [1:0] op, input logic [1:0] bank,
                         input logic [9:0] col, input logic ap, output int vis);
        req_valid = 1'b1; req_op = op; req_bank = bank; req_col = col; req_ap = ap;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        vis = cyc;
    endtask

    // sel 0: rd_valid, sel 1: wr_take; expected high only in [on_lo, on_hi)
    task automatic chk_span(input int sel, input int lo, input int hi,
                            input int on_lo, input int on_hi, input string req);
        int bad_c = -1;
        int bad_a = 0;
        int bad_e = 0;
        for (int c = lo; c < hi; c++) begin
            int a = (sel == 0) ? int'(lg_rv[c]) : int'(lg_wt[c]);
            int e = (c >= on_lo && c < on_hi) ? 1 : 0;
            if (a != e && bad_c < 0) begin bad_c = c; bad_a = a; bad_e = e; end
        end
        chk(bad_c < 0, req, $sformatf("%s at offset %0d", (sel == 0) ? "rd_valid" : "wr_take",
            bad_c - lo), bad_a, bad_e);
    endtask

    // close_mask expected equal to mask at cycle at (none if at < 0), zero elsewhere
    task automatic chk_close(input int lo, input int hi, input int at,
                             input logic [3:0] mask, input string req);
        int bad_c = -1;
        int bad_a = 0;
        int bad_e = 0;
        for (int c = lo; c < hi; c++) begin
            logic [3:0] e = (c == at) ? mask : 4'd0;
            if ((lg_cm[c] !== e || lg_ce[c] !== (e != 4'd0)) && bad_c < 0) begin
                bad_c = c; bad_a = int'(lg_cm[c]); bad_e = int'(e);
            end
        end
        chk(bad_c < 0, req, $sformatf("close_mask at offset %0d", bad_c - lo), bad_a, bad_e);
    endtask

    task automatic t_reset_state;
        chk({sdr_ras_n, sdr_cas_n, sdr_we_n} == 3'b111, "R12", "idle command",
            int'({sdr_ras_n, sdr_cas_n, sdr_we_n}), 7);
        chk(!rd_valid && !wr_take && close_mask == 4'd0, "R12", "strobes low",
            int'({rd_valid, wr_take, close_mask}), 0);
        chk(req_ready, "R12", "ready high", int'(req_ready), 1);
    endtask

    task automatic t_read_plain;
        int c0;
        cfg_bl = 2'd2; cfg_cl = 3'd2;
        issue(2'd0, 2'd1, 10'h055, 1'b0, c0);
        chk({sdr_ras_n, sdr_cas_n, sdr_we_n} == 3'b101, "R1", "read code",
            int'({sdr_ras_n, sdr_cas_n, sdr_we_n}), 5);
        chk(sdr_addr == 13'h055 && sdr_ba == 2'd1, "R1", "read address",
            int'({sdr_ba, sdr_addr}), int'({2'd1, 13'h055}));
        idle(14);
        chk_span(0, c0, c0 + 12, c0 + 2, c0 + 6, "R2");
        chk_span(1, c0, c0 + 12, 0, 0, "R3");
        chk_close(c0, c0 + 12, -1, 4'd0, "R6");
        cfg_bl = 2'd0; cfg_cl = 3'd4;
        issue(2'd0, 2'd0, 10'h001, 1'b0, c0);
        idle(12);
        chk_span(0, c0, c0 + 10, c0 + 4, c0 + 5, "R2");
    endtask

    task automatic t_read_ap;
        int c0;
        cfg_bl = 2'd3; cfg_cl = 3'd3;
        issue(2'd0, 2'd2, 10'h100, 1'b1, c0);
        idle(16);
        chk_span(0, c0, c0 + 14, c0 + 3, c0 + 11, "R2");
        chk_close(c0, c0 + 14, c0 + 8, 4'b0100, "R4");
        cfg_bl = 2'd1; cfg_cl = 3'd4;
        issue(2'd0, 2'd3, 10'h003, 1'b1, c0);
        chk(sdr_addr[10] == 1'b1, "R1", "close flag on bit 10", int'(sdr_addr[10]), 1);
        idle(12);
        chk_span(0, c0, c0 + 10, c0 + 4, c0 + 6, "R2");
        chk_close(c0, c0 + 10, c0 + 2, 4'b1000, "R4");
    endtask

    task automatic t_write_ap;
        int c0;
        cfg_bl = 2'd2; cfg_twr = 3'd2;
        issue(2'd1, 2'd0, 10'h3ff, 1'b1, c0);
        chk({sdr_ras_n, sdr_cas_n, sdr_we_n} == 3'b100, "R1", "write code",
            int'({sdr_ras_n, sdr_cas_n, sdr_we_n}), 4);
        idle(12);
        chk_span(1, c0, c0 + 10, c0, c0 + 4, "R3");
        chk_close(c0, c0 + 10, c0 + 5, 4'b0001, "R5");
        cfg_bl = 2'd0; cfg_twr = 3'd5;
        issue(2'd1, 2'd3, 10'h010, 1'b1, c0);
        idle(12);
        chk_span(1, c0, c0 + 10, c0, c0 + 1, "R3");
        chk_close(c0, c0 + 10, c0 + 5, 4'b1000, "R5");
    endtask

    task automatic t_stop;
        int c0, cs;
        cfg_bl = 2'd3; cfg_twr = 3'd2;
        issue(2'd1, 2'd1, 10'h020, 1'b1, c0);
        idle(1);
        issue(2'd3, 2'd0, 10'h000, 1'b0, cs);
        chk({sdr_ras_n, sdr_cas_n, sdr_we_n} == 3'b110, "R1", "stop code",
            int'({sdr_ras_n, sdr_cas_n, sdr_we_n}), 6);
        idle(16);
        chk_span(1, c0, c0 + 16, c0, cs, "R7");
        chk_close(c0, c0 + 16, -1, 4'd0, "R7");
        cfg_cl = 3'd3;
        issue(2'd0, 2'd2, 10'h040, 1'b1, c0);
        idle(2);
        issue(2'd3, 2'd0, 10'h000, 1'b0, cs);
        idle(16);
        chk_span(0, c0, c0 + 16, c0 + 3, cs + 3, "R7");
        chk_close(c0, c0 + 16, -1, 4'd0, "R7");
    endtask

    task automatic t_interrupt;
        int c0, c1;
        cfg_bl = 2'd3; cfg_cl = 3'd2;
        issue(2'd0, 2'd1, 10'h011, 1'b1, c0);
        idle(1);
        cfg_bl = 2'd1;
        issue(2'd0, 2'd2, 10'h022, 1'b0, c1);
        idle(14);
        chk_span(0, c0, c0 + 14, c0 + 2, c1 + 4, "R8");
        chk_close(c0, c0 + 14, -1, 4'd0, "R8");
        cfg_bl = 2'd3;
        issue(2'd1, 2'd0, 10'h033, 1'b1, c0);
        cfg_bl = 2'd0;
        issue(2'd1, 2'd3, 10'h044, 1'b0, c1);
        idle(14);
        chk_span(1, c0, c0 + 14, c0, c1 + 1, "R8");
        chk_close(c0, c0 + 14, -1, 4'd0, "R8");
    endtask

    task automatic t_precharge;
        int c0, p;
        cfg_bl = 2'd2; cfg_cl = 3'd2;
        issue(2'd0, 2'd1, 10'h005, 1'b0, c0);
        issue(2'd2, 2'd3, 10'h000, 1'b0, p);
        chk({sdr_ras_n, sdr_cas_n, sdr_we_n} == 3'b010 && sdr_ba == 2'd3 && !sdr_addr[10],
            "R9", "precharge on bus", int'({sdr_ras_n, sdr_cas_n, sdr_we_n, sdr_ba}), 11);
        idle(12);
        chk_span(0, c0, c0 + 12, c0 + 2, c0 + 6, "R9");
        chk_close(c0, c0 + 12, p, 4'b1000, "R9");
        cfg_bl = 2'd3;
        issue(2'd0, 2'd1, 10'h006, 1'b0, c0);
        idle(1);
        issue(2'd2, 2'd1, 10'h000, 1'b0, p);
        idle(14);
        chk_span(0, c0, c0 + 14, c0 + 2, p + 2, "R9");
        chk_close(c0, c0 + 14, p, 4'b0010, "R9");
        issue(2'd0, 2'd0, 10'h007, 1'b1, c0);
        issue(2'd2, 2'd3, 10'h000, 1'b1, p);
        chk(sdr_addr[10] == 1'b1, "R9", "all-banks flag", int'(sdr_addr[10]), 1);
        idle(14);
        chk_span(0, c0, c0 + 14, c0 + 2, p + 2, "R9");
        chk_close(c0, c0 + 14, p, 4'b1111, "R9");
    endtask

    task automatic t_turnaround;
        int c0, w;
        cfg_bl = 2'd2; cfg_cl = 3'd3;
        issue(2'd0, 2'd0, 10'h008, 1'b0, c0);
        req_op = 2'd1;
        #1;
        chk(req_ready == 1'b0, "R10", "write held", int'(req_ready), 0);
        issue(2'd1, 2'd2, 10'h009, 1'b0, w);
        chk(w == c0 + 8, "R10", "write command cycle", w - c0, 8);
        idle(12);
        chk_span(0, c0, c0 + 16, c0 + 3, c0 + 7, "R10");
        chk_span(1, c0, c0 + 16, c0 + 8, c0 + 12, "R10");
    endtask

    task automatic t_coincide;
        int c0, p;
        cfg_bl = 2'd0; cfg_twr = 3'd3;
        issue(2'd1, 2'd0, 10'h00a, 1'b1, c0);
        idle(2);
        issue(2'd2, 2'd2, 10'h000, 1'b0, p);
        chk(p == c0 + 3, "R11", "precharge cycle", p - c0, 3);
        idle(10);
        chk_close(c0, c0 + 10, c0 + 3, 4'b0101, "R11");
    endtask

    task automatic t_mid_reset;
        int c0;
        cfg_bl = 2'd3; cfg_cl = 3'd2;
        issue(2'd0, 2'd1, 10'h00b, 1'b1, c0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle(14);
        chk_span(0, c0 + 1, c0 + 14, 0, 0, "R12");
        chk_close(c0 + 1, c0 + 14, -1, 4'd0, "R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_read_plain();
        idle(4);
        t_read_ap();
        idle(4);
        t_write_ap();
        idle(4);
        t_stop();
        idle(4);
        t_interrupt();
        idle(4);
        t_precharge();
        idle(4);
        t_turnaround();
        idle(4);
        t_coincide();
        idle(4);
        t_mid_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule